// File: doc/BRIEF.md
# Split Condition-Flag Rename and Micro-op Cracking Unit

This unit sits in an out-of-order front end and tracks which in-flight producer owns the condition flags. The flags are held as two groups, each renamed on its own. The first group is the carry flag alone. The second group is a cluster of overflow, zero, sign, parity and adjust. Each group has a producer tag. Each cycle the unit can accept one decoded instruction descriptor. The descriptor says which groups the instruction writes, which groups it reads, how many register sources it has, and whether it is a candidate for fusion with the instruction before it. The unit updates the group tags. It then emits the micro-ops for the instruction, giving each one its carry source tag and its cluster source tag.

A micro-op may take at most three inputs. An instruction is split into two micro-ops only when its register sources plus its flag groups exceed that limit. Reading one group that was written by one producer and another group that was written by a different producer does not, by itself, cause a split. An instruction that updates only the zero flag is a partial cluster writer. After such a write, the next reader of the cluster is preceded by one merge micro-op, and that merge becomes the new owner of the whole cluster. Up to `LANES` micro-ops leave the unit per cycle. When an instruction needs more micro-ops than that, the input is held off for the extra cycles.

Top module: `flag_rename_crack`

## Requirements
- R1: After reset, `in_ready` is 1 and all outputs are 0. The carry tag is 0 and the cluster tag is 1, so the first reader sees carry source 0 and cluster source 1. The first tag allocated is 2.
- R2: Each accepted instruction that writes any flag group allocates the next counter value as its producer tag, and a merge micro-op allocates a value before the instruction's own tag. The counter is 6 bits wide and wraps from 63 to 0.
- R3: A carry-only writer (`in_wr_car`=1, `in_wr_clu`=0) changes only the carry tag. A full cluster writer (`in_wr_clu`=2) with `in_wr_car`=0 changes only the cluster tag. A writer of both groups gives both groups the same new tag.
- R4: An instruction whose register sources plus flag groups read come to at most 3 emits exactly one body micro-op. This holds whatever instructions last wrote each group.
- R5: An instruction whose register sources plus flag groups read come to more than 3 emits two body micro-ops, and both carry the same source tags.
- R6: Encoding of `in_wr_clu`: 0 = none, 1 = partial (zero flag only), 2 = full, 3 = none. A partial write stores its tag as the pending partial and leaves the cluster tag unchanged; a second partial write replaces the stored partial tag. The next cluster reader is preceded by a merge micro-op (`out_merge`=1) whose carry-source field holds the partial tag and whose cluster-source field holds the old cluster tag. That merge's tag becomes the cluster tag and clears the pending state. A carry-only reader causes no merge and leaves the pending state in place. A full cluster write clears the pending state without a merge.
- R7: `out_fuse` is 1 only when all of the following hold: `in_fuse_cand` is 1, the instruction reads at least one group, and every group it reads was written by the immediately preceding accepted instruction. For the cluster, only a full write counts.
- R8: Micro-ops appear on the cycle after acceptance, in the order merge, first body, second body, filling lanes from lane 0. `out_total` (1 to 3) and `out_fuse` are held on every output cycle of the instruction. Lanes that are not valid drive 0 tags and 0 `out_merge`.
- R9: When an instruction has more micro-ops than `LANES`, `in_ready` is 0 until the cycle that presents its last micro-op. An `in_valid` pulse while `in_ready` is 0 is not accepted and changes no tag.
- R10: In a cycle following one with neither an acceptance nor remaining micro-ops, `out_valid`, `out_total` and `out_fuse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Descriptor present |
| in_ready | output | 1 | Unit can take a descriptor this cycle |
| in_wr_car | input | 1 | Instruction writes the carry group |
| in_wr_clu | input | 2 | Cluster write kind: 0 none, 1 partial, 2 full, 3 none |
| in_rd_car | input | 1 | Instruction reads the carry group |
| in_rd_clu | input | 1 | Instruction reads the cluster group |
| in_nreg | input | REG_W | Number of register sources (0 to 3) |
| in_fuse_cand | input | 1 | Instruction asks to fuse with the previous one |
| out_valid | output | LANES | Per-lane micro-op valid |
| out_merge | output | LANES | Per-lane marker of a merge micro-op |
| out_src_car | output | LANES*TAG_W | Per-lane carry source tag, lane l at bits l*TAG_W upward |
| out_src_clu | output | LANES*TAG_W | Per-lane cluster source tag, same packing |
| out_total | output | 2 | Micro-op count of the instruction being presented |
| out_fuse | output | 1 | Fusion accepted for the instruction being presented |

## Verification
The bench focuses on the cluster reader that follows a zero-only writer. A unit that skips the merge hands the reader a stale cluster tag. A unit that merges on every mixed-group read emits an extra micro-op for a branch that reads both groups. Cracking is probed at exactly three and at four inputs; an off-by-one limit would split cheap branches or overload a conditional move. Three-micro-op instructions test the stall and the ignored input that arrives during it. Enough allocations are made to cross the wrap from 63 to 0, where a counter that saturates or skips would mismatch every later tag. The fusion rule is checked against carry-reading and cluster-reading branches after each writer kind.

// File: rtl/frc_pkg.sv
package frc_pkg;
  typedef enum logic [1:0] {
    CW_NONE = 2'd0,
    CW_PART = 2'd1,
    CW_FULL = 2'd2,
    CW_RSVD = 2'd3
  } clu_wr_e;
endpackage

// File: rtl/frc_crack_plan.sv
module frc_crack_plan #(
  parameter int REG_W  = 2,
  parameter int MAX_IN = 3,
  parameter int CNT_W  = 2
) (
  input  logic             rd_car,
  input  logic             rd_clu,
  input  logic [REG_W-1:0] nreg,
  input  logic             fuse_cand,
  input  logic             pend,
  input  logic             prev_car,
  input  logic             prev_full,
  output logic             need_merge,
  output logic             split,
  output logic [CNT_W-1:0] total,
  output logic             fuse
);
  localparam int IN_W = REG_W + 2;

  logic [IN_W-1:0] n_in;

  always_comb begin
    n_in       = IN_W'(nreg) + IN_W'(rd_car) + IN_W'(rd_clu);
    need_merge = rd_clu & pend;
    split      = (n_in > IN_W'(MAX_IN));
    total      = CNT_W'(1) + CNT_W'(need_merge) + CNT_W'(split);
    fuse       = fuse_cand & (rd_car | rd_clu)
               & (~rd_car | prev_car) & (~rd_clu | prev_full);
  end
endmodule

// File: rtl/frc_tag_state.sv
module frc_tag_state
  import frc_pkg::*;
#(
  parameter int TAG_W    = 6,
  parameter int INIT_CAR = 0,
  parameter int INIT_CLU = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc,
  input  logic             wr_car,
  input  logic [1:0]       wr_clu,
  input  logic             need_merge,
  output logic [TAG_W-1:0] car_q,
  output logic [TAG_W-1:0] clu_q,
  output logic [TAG_W-1:0] part_q,
  output logic [TAG_W-1:0] mrg_tag,
  output logic [TAG_W-1:0] body_clu,
  output logic             pend_q,
  output logic             prev_car_q,
  output logic             prev_full_q
);
  localparam logic [TAG_W-1:0] CAR0  = TAG_W'(INIT_CAR);
  localparam logic [TAG_W-1:0] CLU0  = TAG_W'(INIT_CLU);
  localparam logic [TAG_W-1:0] FREE0 = TAG_W'(INIT_CLU + 1);

  logic [TAG_W-1:0] cnt_q;
  logic [TAG_W-1:0] wtag;
  logic             is_full;
  logic             is_part;
  logic             writes;

  always_comb begin
    is_full  = (clu_wr_e'(wr_clu) == CW_FULL);
    is_part  = (clu_wr_e'(wr_clu) == CW_PART);
    writes   = wr_car | is_full | is_part;
    wtag     = cnt_q + TAG_W'(need_merge);
    mrg_tag  = cnt_q;
    body_clu = need_merge ? cnt_q : clu_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      car_q       <= CAR0;
      clu_q       <= CLU0;
      part_q      <= '0;
      pend_q      <= 1'b0;
      cnt_q       <= FREE0;
      prev_car_q  <= 1'b0;
      prev_full_q <= 1'b0;
    end else if (acc) begin
      if (need_merge) begin
        clu_q  <= cnt_q;
        pend_q <= 1'b0;
      end
      if (wr_car) car_q <= wtag;
      if (is_full) begin
        clu_q  <= wtag;
        pend_q <= 1'b0;
      end else if (is_part) begin
        part_q <= wtag;
        pend_q <= 1'b1;
      end
      cnt_q       <= wtag + TAG_W'(writes);
      prev_car_q  <= wr_car;
      prev_full_q <= is_full;
    end
  end

  // R6: a merge is requested only while a partial write is outstanding
  a_r6_merge_needs_pending: assert property (@(posedge clk) disable iff (rst)
    (acc && need_merge) |-> pend_q);

  // R6: a merge that is not followed by a new cluster write settles the cluster
  a_r6_merge_settles: assert property (@(posedge clk) disable iff (rst)
    (acc && need_merge && !is_part) |=> !pend_q);

  // R3: carry tag only moves for carry writers
  a_r3_carry_kept: assert property (@(posedge clk) disable iff (rst)
    (acc && !wr_car) |=> (car_q == $past(car_q)));

  // R9: without an acceptance no rename state changes
  a_r9_idle_stable: assert property (@(posedge clk) disable iff (rst)
    !acc |=> ($stable(car_q) && $stable(clu_q) && $stable(pend_q)));
endmodule

// File: rtl/frc_sequencer.sv
module frc_sequencer #(
  parameter int LANES = 2,
  parameter int TAG_W = 6,
  parameter int MAXU  = 3,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc,
  input  logic [CNT_W-1:0] total,
  input  logic             need_merge,
  input  logic             fuse,
  input  logic [TAG_W-1:0] mrg_car,
  input  logic [TAG_W-1:0] mrg_clu,
  input  logic [TAG_W-1:0] body_car,
  input  logic [TAG_W-1:0] body_clu,
  output logic             ready,
  output logic [LANES-1:0] out_valid,
  output logic [LANES-1:0] out_merge,
  output logic [LANES*TAG_W-1:0] out_src_car,
  output logic [LANES*TAG_W-1:0] out_src_clu,
  output logic [CNT_W-1:0] out_total,
  output logic             out_fuse
);
  localparam int POS_W = $clog2(MAXU + LANES + 1);

  logic             n_mrg [MAXU];
  logic [TAG_W-1:0] n_car [MAXU];
  logic [TAG_W-1:0] n_clu [MAXU];
  logic             q_mrg [MAXU];
  logic [TAG_W-1:0] q_car [MAXU];
  logic [TAG_W-1:0] q_clu [MAXU];
  logic             s_mrg [MAXU];
  logic [TAG_W-1:0] s_car [MAXU];
  logic [TAG_W-1:0] s_clu [MAXU];

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] tot_q;
  logic             fuse_q;
  logic [POS_W-1:0] start;
  logic [POS_W-1:0] stot;
  logic             active;

  always_comb begin
    ready  = (pos_q >= tot_q);
    active = acc | (pos_q < tot_q);
    start  = acc ? '0 : pos_q;
    stot   = acc ? POS_W'(total) : tot_q;
  end

  for (genvar i = 0; i < MAXU; i++) begin : g_ent
    always_comb begin
      n_mrg[i] = need_merge && (i == 0);
      n_car[i] = n_mrg[i] ? mrg_car : body_car;
      n_clu[i] = n_mrg[i] ? mrg_clu : body_clu;
      s_mrg[i] = acc ? n_mrg[i] : q_mrg[i];
      s_car[i] = acc ? n_car[i] : q_car[i];
      s_clu[i] = acc ? n_clu[i] : q_clu[i];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        q_mrg[i] <= 1'b0;
        q_car[i] <= '0;
        q_clu[i] <= '0;
      end else if (acc) begin
        q_mrg[i] <= n_mrg[i];
        q_car[i] <= n_car[i];
        q_clu[i] <= n_clu[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q     <= '0;
      tot_q     <= '0;
      fuse_q    <= 1'b0;
      out_total <= '0;
      out_fuse  <= 1'b0;
    end else begin
      if (acc) begin
        tot_q  <= POS_W'(total);
        pos_q  <= POS_W'(LANES);
        fuse_q <= fuse;
      end else if (pos_q < tot_q) begin
        pos_q <= pos_q + POS_W'(LANES);
      end
      out_total <= active ? CNT_W'(stot) : '0;
      out_fuse  <= active & (acc ? fuse : fuse_q);
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic             l_v;
    logic             l_m;
    logic [TAG_W-1:0] l_c;
    logic [TAG_W-1:0] l_k;
    logic             o_v;
    logic             o_m;
    logic [TAG_W-1:0] o_c;
    logic [TAG_W-1:0] o_k;

    always_comb begin
      l_v = active && ((start + POS_W'(l)) < stot);
      l_m = 1'b0;
      l_c = '0;
      l_k = '0;
      for (int j = 0; j < MAXU; j++) begin
        if (l_v && (POS_W'(j) == start + POS_W'(l))) begin
          l_m = s_mrg[j];
          l_c = s_car[j];
          l_k = s_clu[j];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        o_v <= 1'b0;
        o_m <= 1'b0;
        o_c <= '0;
        o_k <= '0;
      end else begin
        o_v <= l_v;
        o_m <= l_m;
        o_c <= l_c;
        o_k <= l_k;
      end
    end

    assign out_valid[l]                   = o_v;
    assign out_merge[l]                   = o_m;
    assign out_src_car[l*TAG_W +: TAG_W]  = o_c;
    assign out_src_clu[l*TAG_W +: TAG_W]  = o_k;
  end

  // R9: an instruction wider than one output cycle holds the input off
  a_r9_stall_wide: assert property (@(posedge clk) disable iff (rst)
    (acc && (POS_W'(total) > POS_W'(LANES))) |=> !ready);

  // R10: nothing accepted and nothing left means quiet outputs
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!acc && ready) |=> (out_valid == '0));

  // R8: lanes fill from lane 0
  a_r8_lane0_first: assert property (@(posedge clk) disable iff (rst)
    (out_valid != '0) |-> out_valid[0]);
endmodule

// File: rtl/flag_rename_crack.sv
module flag_rename_crack #(
  parameter int TAG_W    = 6,
  parameter int LANES    = 2,
  parameter int MAX_IN   = 3,
  parameter int REG_W    = 2,
  parameter int INIT_CAR = 0,
  parameter int INIT_CLU = 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic                   in_wr_car,
  input  logic [1:0]             in_wr_clu,
  input  logic                   in_rd_car,
  input  logic                   in_rd_clu,
  input  logic [REG_W-1:0]       in_nreg,
  input  logic                   in_fuse_cand,
  output logic [LANES-1:0]       out_valid,
  output logic [LANES-1:0]       out_merge,
  output logic [LANES*TAG_W-1:0] out_src_car,
  output logic [LANES*TAG_W-1:0] out_src_clu,
  output logic [1:0]             out_total,
  output logic                   out_fuse
);
  localparam int CNT_W = 2;
  localparam int MAXU  = 3;

  logic             acc;
  logic             need_merge;
  logic             split;
  logic [CNT_W-1:0] total;
  logic             fuse;
  logic [TAG_W-1:0] car_q;
  logic [TAG_W-1:0] clu_q;
  logic [TAG_W-1:0] part_q;
  logic [TAG_W-1:0] mrg_tag;
  logic [TAG_W-1:0] body_clu;
  logic             pend_q;
  logic             prev_car_q;
  logic             prev_full_q;
  logic             split_unused;

  assign acc          = in_valid & in_ready;
  assign split_unused = split;

  frc_crack_plan #(.REG_W(REG_W), .MAX_IN(MAX_IN), .CNT_W(CNT_W)) u_plan (
    .rd_car(in_rd_car), .rd_clu(in_rd_clu), .nreg(in_nreg),
    .fuse_cand(in_fuse_cand), .pend(pend_q), .prev_car(prev_car_q),
    .prev_full(prev_full_q), .need_merge(need_merge), .split(split),
    .total(total), .fuse(fuse)
  );

  frc_tag_state #(.TAG_W(TAG_W), .INIT_CAR(INIT_CAR), .INIT_CLU(INIT_CLU)) u_tags (
    .clk(clk), .rst(rst), .acc(acc), .wr_car(in_wr_car), .wr_clu(in_wr_clu),
    .need_merge(need_merge), .car_q(car_q), .clu_q(clu_q), .part_q(part_q),
    .mrg_tag(mrg_tag), .body_clu(body_clu), .pend_q(pend_q),
    .prev_car_q(prev_car_q), .prev_full_q(prev_full_q)
  );

  frc_sequencer #(.LANES(LANES), .TAG_W(TAG_W), .MAXU(MAXU), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .acc(acc), .total(total), .need_merge(need_merge),
    .fuse(fuse), .mrg_car(part_q), .mrg_clu(clu_q), .body_car(car_q),
    .body_clu(body_clu), .ready(in_ready), .out_valid(out_valid),
    .out_merge(out_merge), .out_src_car(out_src_car), .out_src_clu(out_src_clu),
    .out_total(out_total), .out_fuse(out_fuse)
  );

  // R8: a presented instruction always reports a count of one to three
  a_r8_total_range: assert property (@(posedge clk) disable iff (rst)
    (out_valid != '0) |-> ((out_total >= 2'd1) && (out_total <= 2'd3)));

  // R5: a merge or split is present whenever more than one micro-op is reported
  a_r5_multi_reason: assert property (@(posedge clk) disable iff (rst)
    (acc && (total > 2'd1)) |-> (need_merge || split_unused));
endmodule

// File: tb/flag_rename_crack_tb.sv
module flag_rename_crack_tb;
  localparam int CLK_P = 10;
  localparam int TW    = 6;
  localparam int NL    = 2;

  logic clk = 0;
  logic rst = 1;
  logic in_valid = 0, in_wr_car = 0, in_rd_car = 0, in_rd_clu = 0, in_fuse_cand = 0;
  logic [1:0] in_wr_clu = 0;
  logic [1:0] in_nreg = 0;
  logic in_ready;
  logic [NL-1:0] out_valid, out_merge;
  logic [NL*TW-1:0] out_src_car, out_src_clu;
  logic [1:0] out_total;
  logic out_fuse;

  always #(CLK_P/2) clk = ~clk;

  flag_rename_crack u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_wr_car(in_wr_car), .in_wr_clu(in_wr_clu), .in_rd_car(in_rd_car),
    .in_rd_clu(in_rd_clu), .in_nreg(in_nreg), .in_fuse_cand(in_fuse_cand),
    .out_valid(out_valid), .out_merge(out_merge), .out_src_car(out_src_car),
    .out_src_clu(out_src_clu), .out_total(out_total), .out_fuse(out_fuse)
  );

  typedef struct { bit mrg; int car; int clu; int tot; bit fu; } uop_t;
  uop_t pq[$];

  int m_car, m_clu, m_part, m_cnt;
  bit m_pend, m_pcar, m_pfull;
  bit e_v[NL], e_m[NL];
  int e_c[NL], e_k[NL];
  int e_tot;
  bit e_fu;
  int total = 0, bad = 0;
  bit done = 0;
  string cur_req = "R1";

  task automatic chk(string what, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s got=%0d exp=%0d t=%0t", cur_req, what, got, exp, $time);
    end
  endtask

  task automatic compare();
    chk("ready", in_ready, pq.size() == 0);
    for (int l = 0; l < NL; l++) begin
      chk($sformatf("valid%0d", l), out_valid[l], e_v[l]);
      chk($sformatf("merge%0d", l), out_merge[l], e_m[l]);
      chk($sformatf("car%0d", l), out_src_car[l*TW +: TW], e_c[l]);
      chk($sformatf("clu%0d", l), out_src_clu[l*TW +: TW], e_k[l]);
    end
    chk("total", out_total, e_tot);
    chk("fuse", out_fuse, e_fu);
  endtask

  task automatic model_accept(bit wc, int wk, bit rc, bit rk, int nr, bit fc);
    bit nm, sp, fu, wr;
    int tot, mtag, wtag, bclu;
    uop_t u;
    nm   = rk && m_pend;
    sp   = (nr + rc + rk) > 3;
    tot  = 1 + nm + sp;
    fu   = fc && (rc || rk) && (!rc || m_pcar) && (!rk || m_pfull);
    mtag = m_cnt;
    if (nm) begin u.mrg = 1; u.car = m_part; u.clu = m_clu; u.tot = tot; u.fu = fu; pq.push_back(u); end
    bclu = nm ? mtag : m_clu;
    u.mrg = 0; u.car = m_car; u.clu = bclu; u.tot = tot; u.fu = fu;
    pq.push_back(u);
    if (sp) pq.push_back(u);
    wtag = (m_cnt + nm) % 64;
    wr   = wc || wk == 1 || wk == 2;
    if (nm) begin m_clu = mtag; m_pend = 0; end
    if (wc) m_car = wtag;
    if (wk == 2) begin m_clu = wtag; m_pend = 0; end
    else if (wk == 1) begin m_part = wtag; m_pend = 1; end
    m_cnt  = (wtag + wr) % 64;
    m_pcar = wc;
    m_pfull = (wk == 2);
  endtask

  task automatic cyc(bit v, bit wc, int wk, bit rc, bit rk, int nr, bit fc);
    bit rdy;
    uop_t u;
    compare();
    rdy = (pq.size() == 0);
    in_valid = v; in_wr_car = wc; in_wr_clu = 2'(wk); in_rd_car = rc;
    in_rd_clu = rk; in_nreg = 2'(nr); in_fuse_cand = fc;
    if (v && rdy) model_accept(wc, wk, rc, rk, nr, fc);
    e_tot = 0; e_fu = 0;
    for (int l = 0; l < NL; l++) begin
      e_v[l] = 0; e_m[l] = 0; e_c[l] = 0; e_k[l] = 0;
      if (pq.size() != 0) begin
        u = pq.pop_front();
        e_v[l] = 1; e_m[l] = u.mrg; e_c[l] = u.car; e_k[l] = u.clu;
        e_tot = u.tot; e_fu = u.fu;
      end
    end
    @(negedge clk);
  endtask

  task automatic issue(bit wc, int wk, bit rc, bit rk, int nr, bit fc);
    while (pq.size() != 0) cyc(0, 0, 0, 0, 0, 0, 0);
    cyc(1, wc, wk, rc, rk, nr, fc);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_P * 180000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R9 got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_car = 0; m_clu = 1; m_part = 0; m_cnt = 2; m_pend = 0; m_pcar = 0; m_pfull = 0;
    e_tot = 0; e_fu = 0;
    for (int l = 0; l < NL; l++) begin e_v[l] = 0; e_m[l] = 0; e_c[l] = 0; e_k[l] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset state and initial tags
    cur_req = "R1";
    issue(0, 0, 1, 1, 0, 0);
    issue(1, 0, 0, 0, 0, 0);
    issue(0, 0, 1, 1, 0, 0);
    // R3: single-group and dual-group writers
    cur_req = "R3";
    issue(1, 0, 0, 0, 1, 0);
    issue(0, 0, 1, 1, 0, 0);
    issue(0, 2, 0, 0, 1, 0);
    issue(0, 0, 1, 1, 0, 0);
    issue(1, 2, 0, 0, 2, 0);
    issue(0, 0, 1, 1, 0, 0);
    // R4: mixed-producer reads stay single
    cur_req = "R4";
    issue(0, 2, 0, 0, 1, 0);
    issue(0, 0, 1, 1, 0, 0);
    issue(0, 0, 0, 1, 2, 0);
    issue(0, 0, 1, 0, 2, 0);
    issue(0, 0, 1, 1, 1, 0);
    // R5: four or five inputs split
    cur_req = "R5";
    issue(0, 0, 1, 1, 2, 0);
    issue(0, 0, 1, 1, 3, 0);
    issue(0, 0, 0, 1, 3, 0);
    // R6: partial writes and merges
    cur_req = "R6";
    issue(0, 1, 0, 0, 1, 0);
    issue(0, 0, 1, 0, 1, 0);
    issue(0, 0, 0, 1, 0, 0);
    issue(0, 0, 0, 1, 0, 0);
    issue(0, 1, 0, 0, 1, 0);
    issue(0, 1, 0, 0, 1, 0);
    issue(0, 0, 1, 1, 0, 0);
    issue(0, 1, 0, 0, 1, 0);
    issue(0, 2, 0, 0, 1, 0);
    issue(0, 0, 0, 1, 0, 0);
    issue(0, 1, 0, 0, 1, 0);
    issue(0, 1, 0, 1, 0, 0);
    issue(0, 0, 0, 1, 0, 0);
    // R9: three micro-ops with an ignored pulse during the stall
    cur_req = "R9";
    issue(0, 1, 0, 0, 1, 0);
    cyc(1, 0, 0, 1, 1, 2, 0);
    cyc(1, 1, 2, 0, 0, 0, 0);
    cyc(1, 1, 2, 0, 0, 0, 0);
    idle(2);
    issue(0, 0, 1, 1, 0, 0);
    // R7: fusion decisions
    cur_req = "R7";
    issue(1, 2, 0, 0, 2, 0);
    issue(0, 0, 1, 1, 0, 1);
    issue(0, 2, 0, 0, 1, 0);
    issue(0, 0, 1, 1, 0, 1);
    issue(0, 2, 0, 0, 1, 0);
    issue(0, 0, 0, 1, 0, 1);
    issue(1, 0, 0, 0, 1, 0);
    issue(0, 0, 0, 1, 0, 1);
    issue(1, 0, 0, 0, 1, 0);
    issue(0, 0, 1, 0, 0, 1);
    issue(0, 1, 0, 0, 1, 0);
    issue(0, 0, 0, 1, 0, 1);
    issue(0, 0, 0, 0, 0, 1);
    // R2: counter wraps
    cur_req = "R2";
    for (int i = 0; i < 80; i++) begin
      issue(1, (i % 3 == 0) ? 1 : 2, 0, 0, 1, 0);
      issue(0, 0, 1, 1, 0, 0);
    end
    // R10: idle cycles
    cur_req = "R10";
    idle(4);
    // R8: random traffic against the model
    cur_req = "R8";
    for (int i = 0; i < 4000; i++) begin
      cyc(($urandom % 10) < 7, $urandom % 2, $urandom % 4, $urandom % 2,
          $urandom % 2, $urandom % 4, $urandom % 2);
    end
    idle(3);
    compare();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule